// File: doc/BRIEF.md
# Two-Bit Symbol Sequence Detector

The block watches a stream of 2-bit symbols, one taken on each clock edge where the input-valid strobe is high. It flags a match when it sees an opening symbol (00), then zero or more filler symbols (01), then a closing symbol (11). The filler may repeat without limit or be missing. So the detector does not step through a fixed-length pattern. It keeps one waiting state that it holds for as long as filler arrives.

A fresh opening symbol seen anywhere restarts the partial match. A symbol that cannot continue the pattern drops it. The match output is registered and pulses for one cycle after the closing symbol is accepted. Parameters set the symbol width, the three symbol codes and the state encoding (binary or one-hot). Elaboration checks reject code sets that do not fit the width or are not distinct.

Top module: `sym_seq_detect`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the match output to 0 and discards any partial match, so a closing symbol accepted after reset gives no match.
- R2: Symbol 00 accepted and then symbol 11 accepted on the next valid cycle gives a match, with no filler between them.
- R3: Symbol 00, then any number of 01 symbols, then 11 gives a match.
- R4: match is registered. It is high during the clock cycle after the edge that accepts the closing 11, and it is low again one cycle later.
- R5: Symbol 10 accepted in any state abandons the partial match, so a later 11 gives no match unless a new 00 comes first.
- R6: Symbol 11 or 01 accepted while idle gives no match and does not start a partial match.
- R7: Symbol 00 accepted in any state, including while waiting, restarts the partial match just after the opening symbol.
- R8: Cycles with valid low leave the match progress unchanged, whatever value the symbol input has, and force match to 0.
- R9: After a match the detector is idle, so a second 11 with no new 00 gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Qualifies sym for this cycle |
| sym | input | SYM_W | Incoming symbol (00 open, 01 filler, 11 close, 10 abort with default codes) |
| match | output | 1 | Registered one-cycle match pulse |

## Verification
The detector's only memory is whether it is waiting for a closing symbol. A wrong internal state therefore shows at the ports only when an 11 is accepted. A lost wait state shows as a missing match pulse, and a stale one shows as a spurious pulse. In both cases the pulse appears one cycle after that 11. The stimulus therefore ends every scenario with a closing symbol and checks match after every accepted or idle cycle. This includes gaps with valid low that carry misleading symbol values.

// File: rtl/sym_seq_pkg.sv
package sym_seq_pkg;

   typedef enum logic [1:0] {
      CLS_OPEN  = 2'd0,
      CLS_MID   = 2'd1,
      CLS_CLOSE = 2'd2,
      CLS_OTHER = 2'd3
   } sym_cls_e;

endpackage

// File: rtl/sym_seq_class.sv
module sym_seq_class
   import sym_seq_pkg::*;
#(
   parameter int unsigned SYM_W     = 2,
   parameter int unsigned OPEN_SYM  = 0,
   parameter int unsigned MID_SYM   = 1,
   parameter int unsigned CLOSE_SYM = 3
) (
   input  logic [SYM_W-1:0] sym_i,
   output sym_cls_e         cls_o
);

   localparam logic [SYM_W-1:0] OPEN_C  = SYM_W'(OPEN_SYM);
   localparam logic [SYM_W-1:0] MID_C   = SYM_W'(MID_SYM);
   localparam logic [SYM_W-1:0] CLOSE_C = SYM_W'(CLOSE_SYM);

   always_comb begin
      if (sym_i == OPEN_C)       cls_o = CLS_OPEN;
      else if (sym_i == MID_C)   cls_o = CLS_MID;
      else if (sym_i == CLOSE_C) cls_o = CLS_CLOSE;
      else                       cls_o = CLS_OTHER;
   end

endmodule

// File: rtl/sym_seq_track.sv
module sym_seq_track
   import sym_seq_pkg::*;
#(
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     valid_i,
   input  sym_cls_e cls_i,
   output logic     armed_o
);

   logic armed_n;

   // Progress rule for one accepted symbol
   always_comb begin
      armed_n = armed_o;
      if (valid_i) begin
         unique case (cls_i)
            CLS_OPEN:  armed_n = 1'b1;
            CLS_MID:   armed_n = armed_o;
            CLS_CLOSE: armed_n = 1'b0;
            default:   armed_n = 1'b0;
         endcase
      end
   end

   generate
      if (ONEHOT_STATE) begin : g_onehot
         logic [1:0] st_q; // [0] idle, [1] waiting for close
         always_ff @(posedge clk) begin
            if (rst)     st_q <= 2'b01;
            else         st_q <= armed_n ? 2'b10 : 2'b01;
         end
         assign armed_o = st_q[1];

         AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $countones(st_q) == 1); // R1
      end else begin : g_binary
         logic st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= 1'b0;
            else     st_q <= armed_n;
         end
         assign armed_o = st_q;
      end
   endgenerate

   AST_OPEN_ARMS: assert property (@(posedge clk) disable iff (rst)
      (valid_i && cls_i == CLS_OPEN) |=> armed_o); // R7
   AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (rst)
      (valid_i && cls_i == CLS_OTHER) |=> !armed_o); // R5
   AST_IDLE_MID_STAYS: assert property (@(posedge clk) disable iff (rst)
      (valid_i && cls_i == CLS_MID && !armed_o) |=> !armed_o); // R6
   AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(armed_o)); // R8

endmodule

// File: rtl/sym_seq_hit.sv
module sym_seq_hit
   import sym_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     valid_i,
   input  sym_cls_e cls_i,
   input  logic     armed_i,
   output logic     match_o
);

   always_ff @(posedge clk) begin
      if (rst) match_o <= 1'b0;
      else     match_o <= valid_i && armed_i && (cls_i == CLS_CLOSE);
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      match_o |=> !match_o); // R4

endmodule

// File: rtl/sym_seq_detect.sv
module sym_seq_detect
   import sym_seq_pkg::*;
#(
   parameter int unsigned SYM_W        = 2,
   parameter int unsigned OPEN_SYM     = 0,
   parameter int unsigned MID_SYM      = 1,
   parameter int unsigned CLOSE_SYM    = 3,
   parameter bit          ONEHOT_STATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sym_valid,
   input  logic [SYM_W-1:0] sym,
   output logic             match
);

   localparam longint unsigned SYM_SPAN = 64'd1 << SYM_W;

   generate
      if (SYM_W < 1 || SYM_W > 16) begin : g_bad_width
         $error("sym_seq_detect: SYM_W out of range");
      end
      if (OPEN_SYM >= SYM_SPAN || MID_SYM >= SYM_SPAN || CLOSE_SYM >= SYM_SPAN) begin : g_bad_code
         $error("sym_seq_detect: symbol code exceeds SYM_W");
      end
      if (OPEN_SYM == MID_SYM || OPEN_SYM == CLOSE_SYM || MID_SYM == CLOSE_SYM) begin : g_dup_code
         $error("sym_seq_detect: symbol codes must differ");
      end
   endgenerate

   sym_cls_e cls;
   logic     armed;

   sym_seq_class #(
      .SYM_W     (SYM_W),
      .OPEN_SYM  (OPEN_SYM),
      .MID_SYM   (MID_SYM),
      .CLOSE_SYM (CLOSE_SYM)
   ) class_i (
      .sym_i (sym),
      .cls_o (cls)
   );

   sym_seq_track #(
      .ONEHOT_STATE (ONEHOT_STATE)
   ) track_i (
      .clk     (clk),
      .rst     (rst),
      .valid_i (sym_valid),
      .cls_i   (cls),
      .armed_o (armed)
   );

   sym_seq_hit hit_i (
      .clk     (clk),
      .rst     (rst),
      .valid_i (sym_valid),
      .cls_i   (cls),
      .armed_i (armed),
      .match_o (match)
   );

   AST_IDLE_CLOSE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && cls == CLS_CLOSE && !armed) |=> !match); // R6
   AST_WAIT_CLOSE_HITS: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && cls == CLS_CLOSE && armed) |=> (match && !armed)); // R3
   AST_GAP_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |=> !match); // R8

endmodule

// File: tb/sym_seq_detect_tb_top.sv
module sym_seq_detect_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sym_valid = 1'b0;
   logic [1:0] sym = 2'b00;
   logic       match;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   sym_seq_detect dut_i (
      .clk       (clk),
      .rst       (rst),
      .sym_valid (sym_valid),
      .sym       (sym),
      .match     (match)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (match !== exp) begin
         failures++;
         $display("FAIL %s match=%b expected=%b at %0t", req, match, exp, $time);
      end
   endtask

   // Drive at a falling edge, check at the next falling edge
   task automatic step(input logic v, input logic [1:0] s, input logic exp, input string req);
      sym_valid = v;
      sym = s;
      @(negedge clk);
      check(req, exp);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", 1'b0);
      rst = 1'b0;
      step(1'b0, 2'b00, 1'b0, "R1");
      step(1'b1, 2'b11, 1'b0, "R1");
   endtask

   task automatic t_idle_noise;
      step(1'b1, 2'b01, 1'b0, "R6");
      step(1'b1, 2'b11, 1'b0, "R6");
      step(1'b1, 2'b01, 1'b0, "R6");
      step(1'b1, 2'b11, 1'b0, "R6");
   endtask

   task automatic t_direct;
      step(1'b1, 2'b00, 1'b0, "R2");
      step(1'b1, 2'b11, 1'b1, "R2");
      step(1'b1, 2'b01, 1'b0, "R4");
      step(1'b1, 2'b11, 1'b0, "R9");
   endtask

   task automatic t_repeat;
      step(1'b1, 2'b00, 1'b0, "R3");
      for (int i = 0; i < 6; i++) step(1'b1, 2'b01, 1'b0, "R3");
      step(1'b1, 2'b11, 1'b1, "R3");
      step(1'b0, 2'b11, 1'b0, "R4");
   endtask

   task automatic t_abort;
      step(1'b1, 2'b00, 1'b0, "R5");
      step(1'b1, 2'b01, 1'b0, "R5");
      step(1'b1, 2'b10, 1'b0, "R5");
      step(1'b1, 2'b11, 1'b0, "R5");
      step(1'b1, 2'b00, 1'b0, "R5");
      step(1'b1, 2'b10, 1'b0, "R5");
      step(1'b1, 2'b01, 1'b0, "R5");
      step(1'b1, 2'b11, 1'b0, "R5");
   endtask

   task automatic t_restart;
      step(1'b1, 2'b00, 1'b0, "R7");
      step(1'b1, 2'b01, 1'b0, "R7");
      step(1'b1, 2'b00, 1'b0, "R7");
      step(1'b1, 2'b11, 1'b1, "R7");
      step(1'b1, 2'b00, 1'b0, "R7");
      step(1'b1, 2'b00, 1'b0, "R7");
      step(1'b1, 2'b01, 1'b0, "R7");
      step(1'b1, 2'b11, 1'b1, "R7");
   endtask

   task automatic t_gaps;
      step(1'b1, 2'b00, 1'b0, "R8");
      step(1'b0, 2'b10, 1'b0, "R8");
      step(1'b1, 2'b01, 1'b0, "R8");
      step(1'b0, 2'b11, 1'b0, "R8");
      step(1'b0, 2'b00, 1'b0, "R8");
      step(1'b1, 2'b11, 1'b1, "R8");
      step(1'b0, 2'b11, 1'b0, "R8");
      // gap carrying 00 must not arm
      step(1'b0, 2'b00, 1'b0, "R8");
      step(1'b1, 2'b11, 1'b0, "R8");
   endtask

   task automatic t_reset_mid;
      step(1'b1, 2'b00, 1'b0, "R1");
      rst = 1'b1;
      step(1'b0, 2'b00, 1'b0, "R1");
      rst = 1'b0;
      step(1'b1, 2'b11, 1'b0, "R1");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_idle_noise();
      t_direct();
      t_repeat();
      t_abort();
      t_restart();
      t_gaps();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule